// File: doc/BRIEF.md
# Banked cartridge ROM address mapper

This block turns CPU addresses into physical ROM addresses for a cartridge whose ROM is larger than the CPU's 4 MB window. The CPU window is cut into eight 512 KB slots. Each slot has a bank-select register, and that register picks which 512 KB bank of the ROM the slot shows. A byte-write port loads these registers. Slot 0 is hard-wired to bank 0, so the boot code stays reachable. Writes that name a bank past the configured ROM size are dropped.

Two read translation ports share the slot table. The primary port passes a 24-bit CPU address through the table. The secondary port shows a 1 MB window, picked by a 2-bit window register, that covers two neighbouring slots. When the mapper is disabled, both ports map linearly. Each translation is registered and returns a physical address together with a valid flag. Any change that actually alters the mapping (a slot register or the window register) raises a one-cycle pulse, so that caches of ROM content outside the block can be flushed.

Top module: `rom_bank_mapper`

## Requirements
- R1: After reset, and in every cycle that `map_en` is low, slot register i holds the value i (identity mapping). Register writes made while `map_en` is low are ignored and raise no pulse.
- R2: A write to a register is decoded only when `wr_addr[23:4]` equals 0xA130F. The slot index is `wr_addr[3:1]`, and bit 0 is a don't-care. Writes to any other address leave the table unchanged.
- R3: A write decoded to slot index 0 is ignored, so CPU addresses 0x000000 to 0x07FFFF always map to physical 0x0000000 to 0x007FFFF.
- R4: A write whose value is not less than `rom_banks` (the ROM size in 512 KB banks) is rejected, and the register keeps its old content.
- R5: With `map_en` high, a primary request at address A returns, one cycle later, `pri_phys = {slot[A[21:19]], A[18:0]}`. `pri_valid` is high only when A[23:22] is 0 and the slot value is less than `rom_banks`. `pri_valid` is low in any cycle that follows a cycle with no request.
- R6: With `map_en` low, the primary port returns `pri_phys = A`. `pri_valid` is high when A[23:19] is less than `rom_banks`.
- R7: With `map_en` high, a secondary request at 20-bit offset O, with window value W, uses slot n = 2W + O[19] and returns `{slot[n], O[18:0]}`. It is valid when slot[n] is less than `rom_banks`.
- R8: With `map_en` low, the secondary port returns W × 0x100000 + O. It is valid when {W, O[19]} is less than `rom_banks`.
- R9: When the request's word flag is set, bit 0 of the returned physical address is 0.
- R10: `chg_pulse` is high for exactly the one cycle that follows an accepted register write holding a value different from the register's content, or a window write holding a value different from the current window. A write of an unchanged value raises no pulse.
- R11: A translation requested in the same cycle as a register write uses the register's old value. The new value applies from the next request onward, and the pulse for that write still appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en | input | 1 | Mapper enable; low selects linear mapping |
| rom_banks | input | 9 | ROM size as a count of 512 KB banks |
| wr_en | input | 1 | Register byte-write strobe |
| wr_addr | input | 24 | Byte address of the register write |
| wr_data | input | 8 | Bank value to write |
| win_wr_en | input | 1 | Window register write strobe |
| win_wr_data | input | 2 | New window value (1 MB step) |
| pri_req | input | 1 | Primary translation request |
| pri_addr | input | 24 | Primary CPU address |
| pri_word | input | 1 | Primary 16-bit access (align to even) |
| pri_valid | output | 1 | Primary result inside ROM |
| pri_phys | output | 27 | Primary physical ROM address |
| sec_req | input | 1 | Secondary translation request |
| sec_off | input | 20 | Offset inside the 1 MB secondary window |
| sec_word | input | 1 | Secondary 16-bit access (align to even) |
| sec_valid | output | 1 | Secondary result inside ROM |
| sec_phys | output | 27 | Secondary physical ROM address |
| chg_pulse | output | 1 | One-cycle mapping-change pulse |

## Verification
A register write and a translation that reads the same slot can arrive in one clock cycle. The bench drives, at a single falling edge, a write to slot 6 together with a primary request into slot 6. It then expects the old identity address and the change pulse together. A follow-up request must then return the newly written bank. The bench also writes to slot 0, writes unchanged values and writes values just past the ROM size. For each of these it expects no pulse and an unchanged translation.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  // Register write window: address with its low 4 bits masked off
  localparam logic [23:0] RBM_REG_BASE = 24'hA130F0;
endpackage

// File: rtl/rbm_bank_regs.sv
module rbm_bank_regs
  import rbm_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BANK_W    = 8,
  parameter int NUM_SLOTS = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               map_en,
  input  logic [BANK_W:0]                    rom_banks,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [BANK_W-1:0]                  wr_data,
  input  logic                               win_wr_en,
  input  logic [$clog2(NUM_SLOTS)-2:0]       win_wr_data,
  output logic [NUM_SLOTS-1:0][BANK_W-1:0]   bank_tbl,
  output logic [$clog2(NUM_SLOTS)-2:0]       win_q,
  output logic                               chg_pulse
);
  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int WIN_W = IDX_W - 1;

  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             fits;
  logic             accept;
  logic             win_chg;

  always_comb begin
    in_win  = (wr_addr[ADDR_W-1:4] == RBM_REG_BASE[ADDR_W-1:4]);
    idx     = wr_addr[IDX_W:1];
    fits    = ({1'b0, wr_data} < rom_banks);
    accept  = map_en && wr_en && in_win && (idx != '0) && fits &&
              (bank_tbl[idx] != wr_data);
    win_chg = win_wr_en && (win_wr_data != win_q);
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i == 0) begin : g_fixed
      assign bank_tbl[i] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst || !map_en)
          bank_tbl[i] <= BANK_W'(i);
        else if (accept && (idx == IDX_W'(i)))
          bank_tbl[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q     <= '0;
      chg_pulse <= 1'b0;
    end else begin
      if (win_wr_en)
        win_q <= win_wr_data;
      chg_pulse <= accept || win_chg;
    end
  end

  // R1: disabled mapper holds identity
  assert_identity_R1: assert property (@(posedge clk) disable iff (rst)
    !map_en |=> (bank_tbl[1] == BANK_W'(1)) && (bank_tbl[NUM_SLOTS-1] == BANK_W'(NUM_SLOTS-1)));
  // R3: slot 0 writes change nothing
  assert_slot0_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (map_en && wr_en && in_win && idx == '0) |=> $stable(bank_tbl));
  // R4: out-of-range values rejected
  assert_reject_oob_R4: assert property (@(posedge clk) disable iff (rst)
    (map_en && wr_en && !fits) |=> $stable(bank_tbl));
  // R2: a good write lands in the decoded slot
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (map_en && wr_en && in_win && idx != '0 && fits) |=>
      (bank_tbl[$past(idx)] == $past(wr_data)));
  // R10: a pulse always has a write behind it
  assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (rst)
    chg_pulse |-> $past(wr_en || win_wr_en));
endmodule

// File: rtl/rbm_pri_xlate.sv
module rbm_pri_xlate #(
  parameter int ADDR_W    = 24,
  parameter int BANK_W    = 8,
  parameter int SLOT_W    = 19,
  parameter int NUM_SLOTS = 8,
  parameter int PHYS_W    = BANK_W + SLOT_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             map_en,
  input  logic [BANK_W:0]                  rom_banks,
  input  logic [NUM_SLOTS-1:0][BANK_W-1:0] bank_tbl,
  input  logic                             req,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             word,
  output logic                             valid,
  output logic [PHYS_W-1:0]                phys
);
  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int TOP_W = ADDR_W - SLOT_W;

  logic [IDX_W-1:0]  slot;
  logic [BANK_W-1:0] bank;
  logic [PHYS_W-1:0] phys_n;
  logic              ok;

  always_comb begin
    slot = addr[SLOT_W+IDX_W-1:SLOT_W];
    bank = bank_tbl[slot];
    if (map_en) begin
      phys_n = {bank, addr[SLOT_W-1:0]};
      ok     = (addr[ADDR_W-1:SLOT_W+IDX_W] == '0) && ({1'b0, bank} < rom_banks);
    end else begin
      phys_n = PHYS_W'(addr);
      ok     = ((BANK_W+1)'(addr[ADDR_W-1:SLOT_W]) < rom_banks);
    end
    if (word)
      phys_n[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      phys  <= '0;
    end else begin
      valid <= req && ok;
      if (req)
        phys <= phys_n;
    end
  end

  // R5: a valid result lies inside the ROM
  assert_pri_in_rom_R5: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((BANK_W+1)'(phys[PHYS_W-1:SLOT_W]) < $past(rom_banks)));
  // R5: no request, no valid
  assert_pri_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !req |=> !valid);
  // R9: word accesses come back even
  assert_pri_word_R9: assert property (@(posedge clk) disable iff (rst)
    (req && word) |=> !phys[0]);
  localparam int UNUSED_TOP = TOP_W;
endmodule

// File: rtl/rbm_sec_xlate.sv
module rbm_sec_xlate #(
  parameter int BANK_W    = 8,
  parameter int SLOT_W    = 19,
  parameter int NUM_SLOTS = 8,
  parameter int PHYS_W    = BANK_W + SLOT_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             map_en,
  input  logic [BANK_W:0]                  rom_banks,
  input  logic [NUM_SLOTS-1:0][BANK_W-1:0] bank_tbl,
  input  logic [$clog2(NUM_SLOTS)-2:0]     win,
  input  logic                             req,
  input  logic [SLOT_W:0]                  off,
  input  logic                             word,
  output logic                             valid,
  output logic [PHYS_W-1:0]                phys
);
  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int LIN_W = IDX_W + SLOT_W;

  logic [IDX_W-1:0]  slot;
  logic [BANK_W-1:0] bank;
  logic [LIN_W-1:0]  lin;
  logic [PHYS_W-1:0] phys_n;
  logic              ok;

  always_comb begin
    slot = {win, off[SLOT_W]};
    bank = bank_tbl[slot];
    lin  = {win, off};
    if (map_en) begin
      phys_n = {bank, off[SLOT_W-1:0]};
      ok     = ({1'b0, bank} < rom_banks);
    end else begin
      phys_n = PHYS_W'(lin);
      ok     = ((BANK_W+1)'(slot) < rom_banks);
    end
    if (word)
      phys_n[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      phys  <= '0;
    end else begin
      valid <= req && ok;
      if (req)
        phys <= phys_n;
    end
  end

  // R7: a valid result lies inside the ROM
  assert_sec_in_rom_R7: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((BANK_W+1)'(phys[PHYS_W-1:SLOT_W]) < $past(rom_banks)));
  // R8: linear mode keeps the offset's low bits
  assert_sec_linear_R8: assert property (@(posedge clk) disable iff (rst)
    (req && !map_en && !word) |=> (phys[SLOT_W-1:0] == $past(off[SLOT_W-1:0])));
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper #(
  parameter int ADDR_W    = 24,
  parameter int BANK_W    = 8,
  parameter int SLOT_W    = 19,
  parameter int NUM_SLOTS = 8,
  localparam int WIN_W    = $clog2(NUM_SLOTS) - 1,
  localparam int PHYS_W   = BANK_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_en,
  input  logic [BANK_W:0]   rom_banks,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_data,
  input  logic              win_wr_en,
  input  logic [WIN_W-1:0]  win_wr_data,
  input  logic              pri_req,
  input  logic [ADDR_W-1:0] pri_addr,
  input  logic              pri_word,
  output logic              pri_valid,
  output logic [PHYS_W-1:0] pri_phys,
  input  logic              sec_req,
  input  logic [SLOT_W:0]   sec_off,
  input  logic              sec_word,
  output logic              sec_valid,
  output logic [PHYS_W-1:0] sec_phys,
  output logic              chg_pulse
);
  logic [NUM_SLOTS-1:0][BANK_W-1:0] bank_tbl;
  logic [WIN_W-1:0]                 win_q;

  rbm_bank_regs #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk(clk), .rst(rst), .map_en(map_en), .rom_banks(rom_banks),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_wr_en(win_wr_en), .win_wr_data(win_wr_data),
    .bank_tbl(bank_tbl), .win_q(win_q), .chg_pulse(chg_pulse)
  );

  rbm_pri_xlate #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W),
                  .NUM_SLOTS(NUM_SLOTS), .PHYS_W(PHYS_W)) u_pri (
    .clk(clk), .rst(rst), .map_en(map_en), .rom_banks(rom_banks),
    .bank_tbl(bank_tbl), .req(pri_req), .addr(pri_addr), .word(pri_word),
    .valid(pri_valid), .phys(pri_phys)
  );

  rbm_sec_xlate #(.BANK_W(BANK_W), .SLOT_W(SLOT_W),
                  .NUM_SLOTS(NUM_SLOTS), .PHYS_W(PHYS_W)) u_sec (
    .clk(clk), .rst(rst), .map_en(map_en), .rom_banks(rom_banks),
    .bank_tbl(bank_tbl), .win(win_q), .req(sec_req), .off(sec_off), .word(sec_word),
    .valid(sec_valid), .phys(sec_phys)
  );
endmodule

// File: tb/rom_bank_mapper_bench.sv
module rom_bank_mapper_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        map_en;
  logic [8:0]  rom_banks;
  logic        wr_en;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;
  logic        win_wr_en;
  logic [1:0]  win_wr_data;
  logic        pri_req;
  logic [23:0] pri_addr;
  logic        pri_word;
  logic        pri_valid;
  logic [26:0] pri_phys;
  logic        sec_req;
  logic [19:0] sec_off;
  logic        sec_word;
  logic        sec_valid;
  logic [26:0] sec_phys;
  logic        chg_pulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_bank_mapper u_rom_bank_mapper (
    .clk(clk), .rst(rst), .map_en(map_en), .rom_banks(rom_banks),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_wr_en(win_wr_en), .win_wr_data(win_wr_data),
    .pri_req(pri_req), .pri_addr(pri_addr), .pri_word(pri_word),
    .pri_valid(pri_valid), .pri_phys(pri_phys),
    .sec_req(sec_req), .sec_off(sec_off), .sec_word(sec_word),
    .sec_valid(sec_valid), .sec_phys(sec_phys), .chg_pulse(chg_pulse)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Each helper starts and ends at a falling edge; results are visible on return.
  task automatic reg_write(logic [23:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic win_write(logic [1:0] w);
    win_wr_en = 1'b1; win_wr_data = w;
    @(negedge clk);
    win_wr_en = 1'b0;
  endtask

  task automatic pri_read(logic [23:0] a, logic w);
    pri_req = 1'b1; pri_addr = a; pri_word = w;
    @(negedge clk);
    pri_req = 1'b0; pri_word = 1'b0;
  endtask

  task automatic sec_read(logic [19:0] o, logic w);
    sec_req = 1'b1; sec_off = o; sec_word = w;
    @(negedge clk);
    sec_req = 1'b0; sec_word = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pulse after reset", chg_pulse, 0);
    chk("R5 pri_valid after reset", pri_valid, 0);
    chk("R7 sec_valid after reset", sec_valid, 0);
    pri_read(24'h280123, 0);
    chk("R1 identity valid", pri_valid, 1);
    chk("R1 identity phys", pri_phys, 27'h0280123);
  endtask

  task automatic t_remap;
    reg_write(24'hA130FB, 8'd12);
    chk("R10 pulse on remap", chg_pulse, 1);
    pri_read(24'h280123, 0);
    chk("R10 pulse lasts one cycle", chg_pulse, 0);
    chk("R2 remapped phys", pri_phys, 27'h0600123);
    chk("R5 remapped valid", pri_valid, 1);
    reg_write(24'hA130FA, 8'd12);
    chk("R10 same value no pulse", chg_pulse, 0);
  endtask

  task automatic t_slot0;
    reg_write(24'hA130F1, 8'd9);
    chk("R3 slot0 write no pulse", chg_pulse, 0);
    pri_read(24'h000010, 0);
    chk("R3 slot0 still bank 0", pri_phys, 27'h0000010);
  endtask

  task automatic t_bounds;
    reg_write(24'hA130F7, 8'd16);
    chk("R4 oob write no pulse", chg_pulse, 0);
    pri_read(24'h180000, 0);
    chk("R4 oob write kept old", pri_phys, 27'h0180000);
    reg_write(24'hA130F7, 8'd15);
    chk("R4 last bank accepted pulse", chg_pulse, 1);
    pri_read(24'h180000, 0);
    chk("R4 last bank phys", pri_phys, 27'h0780000);
  endtask

  task automatic t_decode;
    reg_write(24'hA131F7, 8'd4);
    chk("R2 foreign address no pulse", chg_pulse, 0);
    pri_read(24'h180000, 0);
    chk("R2 foreign address ignored", pri_phys, 27'h0780000);
  endtask

  task automatic t_pri_edges;
    pri_read(24'h400000, 0);
    chk("R5 above 4MB invalid", pri_valid, 0);
    pri_read(24'h280123, 1);
    chk("R9 word aligns primary", pri_phys, 27'h0600122);
    @(negedge clk);
    chk("R5 idle cycle not valid", pri_valid, 0);
  endtask

  task automatic t_window;
    win_write(2'd1);
    chk("R10 window change pulse", chg_pulse, 1);
    sec_read(20'h80004, 0);
    chk("R7 upper half slot 3", sec_phys, 27'h0780004);
    chk("R7 upper half valid", sec_valid, 1);
    sec_read(20'h00004, 0);
    chk("R7 lower half slot 2", sec_phys, 27'h0100004);
    win_write(2'd1);
    chk("R10 same window no pulse", chg_pulse, 0);
    win_write(2'd2);
    sec_read(20'h80001, 1);
    chk("R9 word aligns secondary slot 5", sec_phys, 27'h0600000);
  endtask

  task automatic t_collide;
    wr_en = 1'b1; wr_addr = 24'hA130FD; wr_data = 8'd10;
    pri_req = 1'b1; pri_addr = 24'h300000;
    @(negedge clk);
    wr_en = 1'b0; pri_req = 1'b0;
    chk("R11 same-cycle read sees old", pri_phys, 27'h0300000);
    chk("R11 same-cycle pulse", chg_pulse, 1);
    pri_read(24'h300000, 0);
    chk("R11 next read sees new", pri_phys, 27'h0500000);
  endtask

  task automatic t_disabled;
    map_en = 1'b0;
    @(negedge clk);
    reg_write(24'hA130FB, 8'd1);
    chk("R1 disabled write no pulse", chg_pulse, 0);
    pri_read(24'h600123, 0);
    chk("R6 linear phys", pri_phys, 27'h0600123);
    chk("R6 linear valid", pri_valid, 1);
    pri_read(24'h900000, 0);
    chk("R6 linear past ROM invalid", pri_valid, 0);
    sec_read(20'h00010, 0);
    chk("R8 linear window phys", sec_phys, 27'h0200010);
    chk("R8 linear window valid", sec_valid, 1);
    map_en = 1'b1;
    @(negedge clk);
    pri_read(24'h280000, 0);
    chk("R1 identity after re-enable", pri_phys, 27'h0280000);
  endtask

  task automatic t_small_rom;
    rom_banks = 9'd6;
    pri_read(24'h380000, 0);
    chk("R5 slot past small ROM invalid", pri_valid, 0);
    reg_write(24'hA130F3, 8'd6);
    chk("R4 small ROM reject", chg_pulse, 0);
    reg_write(24'hA130F3, 8'd5);
    chk("R4 small ROM accept", chg_pulse, 1);
    win_write(2'd3);
    sec_read(20'h00000, 0);
    chk("R7 window slot past ROM invalid", sec_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; map_en = 1'b1; rom_banks = 9'd16;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    win_wr_en = 0; win_wr_data = '0;
    pri_req = 0; pri_addr = '0; pri_word = 0;
    sec_req = 0; sec_off = '0; sec_word = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_remap();
    t_slot0();
    t_bounds();
    t_decode();
    t_pri_edges();
    t_window();
    t_collide();
    t_disabled();
    t_small_rom();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule